// File: doc/BRIEF.md
# Software Interrupt Fan-Out with Per-Target Pending

This block raises software interrupts between processors. A single command carries an interrupt number, a mask of destination processors and the number of the processor that issued it. For every destination in the mask the block records one pending entry, indexed by interrupt number and requester. Each destination then owns that entry and clears it on its own. One processor taking an interrupt leaves the copies held for the other processors pending.

Each destination processor sees one presented entry: the most urgent pending interrupt number, together with the number of the processor that requested it. Urgency comes from a static per-number priority input. A lower value is more urgent, and a tie goes to the lower interrupt number. When several requesters are pending on the same number, the lowest requester is presented first. An acknowledge from a destination consumes exactly the entry it is being shown. The next pending entry appears in the following cycle.

Top module: `swint_fanout`

## Requirements
- R1: After reset no destination has a pending entry: every bit of `pend_valid_o` is 0.
- R2: A command with `cmd_valid_i` high sets the entry (`cmd_num_i`, `cmd_requester_i`) pending for every destination whose bit in `cmd_dest_i` is 1. It is visible at the outputs one clock later. Destinations whose bit is 0 are unchanged.
- R3: A command is an edge event. Repeating the same command while the entry is still pending adds nothing, so one acknowledge empties it. Once cleared, an entry stays clear until a new command.
- R4: An acknowledge on `ack_i[t]` clears only the entry presented to destination t. All other destinations keep their pending entries.
- R5: For each destination t, `pend_requester_o[t*3 +: 3]` gives the requester number stored with the presented entry, and `pend_num_o[t*4 +: 4]` gives its interrupt number.
- R6: Among pending numbers, destination t is shown the one whose 8-bit field `prio_cfg_i[n*8 +: 8]` is smallest. On equal values the lower interrupt number is shown.
- R7: When several requesters are pending on the same number for one destination, the lowest requester number is presented first. The next one follows after each acknowledge.
- R8: A command that sets the very entry being acknowledged in the same cycle leaves that entry pending.
- R9: An acknowledge to a destination with nothing pending has no effect.
- R10: A command whose destination mask is all zero sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle per request |
| cmd_num_i | input | 4 | Interrupt number of the command |
| cmd_dest_i | input | 8 | Destination processor mask |
| cmd_requester_i | input | 3 | Number of the issuing processor |
| prio_cfg_i | input | 128 | Priority per interrupt number, 8 bits each, lower is more urgent |
| ack_i | input | 8 | Per-destination acknowledge of the presented entry |
| pend_valid_o | output | 8 | Destination has a pending entry |
| pend_num_o | output | 32 | Presented interrupt number, 4 bits per destination |
| pend_requester_o | output | 24 | Requester of the presented entry, 3 bits per destination |

## Verification
Commands are sent to single destinations, to pairs of destinations, to all eight and to none. These cases separate per-destination ownership from shared clearing and catch any leak across the mask. Priority patterns with one strict winner and one tie check the comparison and the tie rule on interrupt number. Several requesters queued on the same number check the requester order. A command that collides with an acknowledge of the same entry, and an acknowledge of an empty destination, check the set/clear precedence and whether spurious clears are ignored.

// File: rtl/swint_pkg.sv
package swint_pkg;

   // Default geometry of the block
   localparam int DEF_CPUS   = 8;
   localparam int DEF_IDS    = 16;
   localparam int DEF_PRIO_W = 8;

   // Structure of the per-destination priority selector
   typedef enum logic [0:0] {
      ARB_LINEAR = 1'b0,
      ARB_TREE   = 1'b1
   } arb_kind_e;

endpackage

// File: rtl/swint_src_pick.sv
module swint_src_pick #(
   parameter  int N_SRC = swint_pkg::DEF_CPUS,
   localparam int SRC_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0] req_i,
   output logic             any_o,
   output logic [SRC_W-1:0] idx_o
);

   // Lowest requester index wins
   always_comb begin
      any_o = |req_i;
      idx_o = '0;
      for (int s = N_SRC - 1; s >= 0; s--) begin
         if (req_i[s]) idx_o = SRC_W'(s);
      end
   end

endmodule

// File: rtl/swint_prio_arb.sv
module swint_prio_arb #(
   parameter  int                   N_ID     = swint_pkg::DEF_IDS,
   parameter  int                   PRIO_W   = swint_pkg::DEF_PRIO_W,
   parameter  swint_pkg::arb_kind_e ARB_KIND = swint_pkg::ARB_TREE,
   localparam int                   ID_W     = $clog2(N_ID)
) (
   input  logic [N_ID-1:0]        cand_i,
   input  logic [N_ID*PRIO_W-1:0] prio_i,
   output logic                   win_valid_o,
   output logic [ID_W-1:0]        win_id_o
);

   generate
      if (ARB_KIND == swint_pkg::ARB_TREE) begin : g_tree
         localparam int NODES = 2 * N_ID - 1;
         logic              node_v [NODES];
         logic [ID_W-1:0]   node_id[NODES];
         logic [PRIO_W-1:0] node_p [NODES];

         // Heap-ordered reduction: leaves hold ids in order, left child
         // always covers lower ids, so a tie keeps the left side.
         always_comb begin
            for (int k = 0; k < N_ID; k++) begin
               node_v [N_ID - 1 + k] = cand_i[k];
               node_id[N_ID - 1 + k] = ID_W'(k);
               node_p [N_ID - 1 + k] = prio_i[k*PRIO_W +: PRIO_W];
            end
            for (int n = N_ID - 2; n >= 0; n--) begin
               if (node_v[2*n+2] &&
                   (!node_v[2*n+1] || (node_p[2*n+2] < node_p[2*n+1]))) begin
                  node_id[n] = node_id[2*n+2];
                  node_p[n]  = node_p[2*n+2];
               end else begin
                  node_id[n] = node_id[2*n+1];
                  node_p[n]  = node_p[2*n+1];
               end
               node_v[n] = node_v[2*n+1] | node_v[2*n+2];
            end
         end

         assign win_valid_o = node_v[0];
         assign win_id_o    = node_id[0];
      end else begin : g_linear
         logic [PRIO_W-1:0] best_p;

         // Ascending scan, strict compare keeps the lower id on a tie
         always_comb begin
            win_valid_o = 1'b0;
            win_id_o    = '0;
            best_p      = '1;
            for (int k = 0; k < N_ID; k++) begin
               if (cand_i[k] &&
                   (!win_valid_o || (prio_i[k*PRIO_W +: PRIO_W] < best_p))) begin
                  win_valid_o = 1'b1;
                  win_id_o    = ID_W'(k);
                  best_p      = prio_i[k*PRIO_W +: PRIO_W];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/swint_target_slot.sv
module swint_target_slot #(
   parameter  int                   N_ID     = swint_pkg::DEF_IDS,
   parameter  int                   N_SRC    = swint_pkg::DEF_CPUS,
   parameter  int                   PRIO_W   = swint_pkg::DEF_PRIO_W,
   parameter  swint_pkg::arb_kind_e ARB_KIND = swint_pkg::ARB_TREE,
   localparam int                   ID_W     = $clog2(N_ID),
   localparam int                   SRC_W    = $clog2(N_SRC)
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   set_i,
   input  logic [ID_W-1:0]        set_num_i,
   input  logic [SRC_W-1:0]       set_src_i,
   input  logic                   ack_i,
   input  logic [N_ID*PRIO_W-1:0] prio_i,
   output logic                   valid_o,
   output logic [ID_W-1:0]        num_o,
   output logic [SRC_W-1:0]       src_o
);

   // One pending bit per (interrupt number, requester)
   logic [N_SRC-1:0] pend_q [N_ID];
   logic [N_ID-1:0]  num_any;
   logic [SRC_W-1:0] num_src [N_ID];
   logic             win_v;
   logic [ID_W-1:0]  win_id;

   generate
      for (genvar g = 0; g < N_ID; g++) begin : g_pick
         swint_src_pick #(
            .N_SRC (N_SRC)
         ) pick_i (
            .req_i (pend_q[g]),
            .any_o (num_any[g]),
            .idx_o (num_src[g])
         );
      end
   endgenerate

   swint_prio_arb #(
      .N_ID     (N_ID),
      .PRIO_W   (PRIO_W),
      .ARB_KIND (ARB_KIND)
   ) arb_i (
      .cand_i      (num_any),
      .prio_i      (prio_i),
      .win_valid_o (win_v),
      .win_id_o    (win_id)
   );

   assign valid_o = win_v;
   assign num_o   = win_id;
   assign src_o   = num_src[win_id];

   // Clear the presented entry, then apply the set so a colliding
   // command keeps its entry pending.
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int i = 0; i < N_ID; i++) pend_q[i] <= '0;
      end else begin
         if (ack_i && win_v) pend_q[win_id][num_src[win_id]] <= 1'b0;
         if (set_i)          pend_q[set_num_i][set_src_i]    <= 1'b1;
      end
   end

endmodule

// File: rtl/swint_fanout.sv
module swint_fanout #(
   parameter  int                   N_CPU    = swint_pkg::DEF_CPUS,
   parameter  int                   N_ID     = swint_pkg::DEF_IDS,
   parameter  int                   PRIO_W   = swint_pkg::DEF_PRIO_W,
   parameter  swint_pkg::arb_kind_e ARB_KIND = swint_pkg::ARB_TREE,
   localparam int                   ID_W     = $clog2(N_ID),
   localparam int                   SRC_W    = $clog2(N_CPU)
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    cmd_valid_i,
   input  logic [ID_W-1:0]         cmd_num_i,
   input  logic [N_CPU-1:0]        cmd_dest_i,
   input  logic [SRC_W-1:0]        cmd_requester_i,
   input  logic [N_ID*PRIO_W-1:0]  prio_cfg_i,
   input  logic [N_CPU-1:0]        ack_i,
   output logic [N_CPU-1:0]        pend_valid_o,
   output logic [N_CPU*ID_W-1:0]   pend_num_o,
   output logic [N_CPU*SRC_W-1:0]  pend_requester_o
);

   // Elaboration-time parameter checks
   generate
      if (N_CPU < 2 || (1 << SRC_W) != N_CPU) begin : g_bad_cpu
         $error("swint_fanout: N_CPU must be a power of two, at least 2");
      end
      if (N_ID < 2 || (1 << ID_W) != N_ID) begin : g_bad_id
         $error("swint_fanout: N_ID must be a power of two, at least 2");
      end
      if (PRIO_W < 1) begin : g_bad_prio
         $error("swint_fanout: PRIO_W must be positive");
      end
   endgenerate

   // One independent slot per destination processor
   generate
      for (genvar t = 0; t < N_CPU; t++) begin : g_dest
         swint_target_slot #(
            .N_ID     (N_ID),
            .N_SRC    (N_CPU),
            .PRIO_W   (PRIO_W),
            .ARB_KIND (ARB_KIND)
         ) slot_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .set_i     (cmd_valid_i & cmd_dest_i[t]),
            .set_num_i (cmd_num_i),
            .set_src_i (cmd_requester_i),
            .ack_i     (ack_i[t]),
            .prio_i    (prio_cfg_i),
            .valid_o   (pend_valid_o[t]),
            .num_o     (pend_num_o[t*ID_W +: ID_W]),
            .src_o     (pend_requester_o[t*SRC_W +: SRC_W])
         );
      end
   endgenerate

endmodule

// File: rtl/swint_fanout_chk.sv
module swint_fanout_chk #(
   parameter int N_CPU = 8,
   parameter int ID_W  = 4,
   parameter int SRC_W = 3
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic                   cmd_valid_i,
   input logic [N_CPU-1:0]       cmd_dest_i,
   input logic [N_CPU-1:0]       ack_i,
   input logic [N_CPU-1:0]       pend_valid_o,
   input logic [N_CPU*ID_W-1:0]  pend_num_o,
   input logic [N_CPU*SRC_W-1:0] pend_requester_o
);

   // R1: leaving reset, nothing is pending
   a_r1_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (pend_valid_o == '0));

   // R2, R8: every addressed destination is pending one cycle after a command
   a_r2_dest_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_valid_i |=> ((pend_valid_o & $past(cmd_dest_i)) == $past(cmd_dest_i)));

   // R3, R10: no destination becomes pending without an addressing command
   a_r3_no_spontaneous: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((pend_valid_o & ~$past(pend_valid_o) &
                 ~($past(cmd_dest_i) & {N_CPU{$past(cmd_valid_i)}})) == '0));

   // R4: a destination that was not acknowledged keeps its pending state
   a_r4_unacked_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (($past(pend_valid_o) & ~$past(ack_i) & ~pend_valid_o) == '0));

   // R9: with no command and no acknowledge, the outputs hold
   a_r9_quiet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cmd_valid_i && ack_i == '0) |=>
         ($stable(pend_valid_o) && $stable(pend_num_o) && $stable(pend_requester_o)));

endmodule

bind swint_fanout swint_fanout_chk #(
   .N_CPU (N_CPU),
   .ID_W  (ID_W),
   .SRC_W (SRC_W)
) chk_i (
   .clk_i            (clk_i),
   .rst_ni           (rst_ni),
   .cmd_valid_i      (cmd_valid_i),
   .cmd_dest_i       (cmd_dest_i),
   .ack_i            (ack_i),
   .pend_valid_o     (pend_valid_o),
   .pend_num_o       (pend_num_o),
   .pend_requester_o (pend_requester_o)
);

// File: tb/swint_fanout_tb_top.sv
module swint_fanout_tb_top;

   logic         clk_i = 1'b0;
   logic         rst_ni = 1'b0;
   logic         cmd_valid_i = 1'b0;
   logic [3:0]   cmd_num_i = '0;
   logic [7:0]   cmd_dest_i = '0;
   logic [2:0]   cmd_requester_i = '0;
   logic [127:0] prio_cfg_i = {16{8'h80}};
   logic [7:0]   ack_i = '0;
   logic [7:0]   pend_valid_o;
   logic [31:0]  pend_num_o;
   logic [23:0]  pend_requester_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk_i = ~clk_i;

   swint_fanout dut_i (
      .clk_i            (clk_i),
      .rst_ni           (rst_ni),
      .cmd_valid_i      (cmd_valid_i),
      .cmd_num_i        (cmd_num_i),
      .cmd_dest_i       (cmd_dest_i),
      .cmd_requester_i  (cmd_requester_i),
      .prio_cfg_i       (prio_cfg_i),
      .ack_i            (ack_i),
      .pend_valid_o     (pend_valid_o),
      .pend_num_o       (pend_num_o),
      .pend_requester_o (pend_requester_o)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_dest(input string req, input int t,
                             input logic [3:0] num, input logic [2:0] src);
      check(req, $sformatf("valid[%0d]", t), 32'(pend_valid_o[t]), 32'd1);
      check(req, $sformatf("num[%0d]", t), 32'(pend_num_o[t*4 +: 4]), 32'(num));
      check(req, $sformatf("requester[%0d]", t), 32'(pend_requester_o[t*3 +: 3]), 32'(src));
   endtask

   // Drive at a falling edge, hold across one rising edge, release.
   task automatic send_cmd(input logic [3:0] num, input logic [7:0] dest,
                           input logic [2:0] src);
      cmd_valid_i = 1'b1; cmd_num_i = num; cmd_dest_i = dest; cmd_requester_i = src;
      @(negedge clk_i);
      cmd_valid_i = 1'b0; cmd_dest_i = '0;
   endtask

   task automatic send_ack(input logic [7:0] mask);
      ack_i = mask;
      @(negedge clk_i);
      ack_i = '0;
   endtask

   task automatic t_reset;
      check("R1", "valid after reset", 32'(pend_valid_o), 32'h0);
   endtask

   task automatic t_basic;
      send_cmd(4'd5, 8'b0000_0101, 3'd3);
      check("R2", "valid mask", 32'(pend_valid_o), 32'h05);
      check_dest("R5", 0, 4'd5, 3'd3);
      check_dest("R5", 2, 4'd5, 3'd3);
      send_ack(8'b0000_0001);
      check("R4", "only dest 0 cleared", 32'(pend_valid_o), 32'h04);
      check_dest("R4", 2, 4'd5, 3'd3);
      send_ack(8'b0000_0100);
      check("R4", "dest 2 cleared", 32'(pend_valid_o), 32'h00);
      send_ack(8'b0000_0101);
      check("R9", "ack on empty", 32'(pend_valid_o), 32'h00);
      repeat (3) @(negedge clk_i);
      check("R3", "no re-raise", 32'(pend_valid_o), 32'h00);
   endtask

   task automatic t_repeat;
      send_cmd(4'd2, 8'b0000_0010, 3'd1);
      send_cmd(4'd2, 8'b0000_0010, 3'd1);
      check_dest("R3", 1, 4'd2, 3'd1);
      send_ack(8'b0000_0010);
      check("R3", "single ack empties", 32'(pend_valid_o), 32'h00);
   endtask

   task automatic t_priority;
      prio_cfg_i[3*8 +: 8]  = 8'h40;
      prio_cfg_i[9*8 +: 8]  = 8'h10;
      prio_cfg_i[12*8 +: 8] = 8'h10;
      send_cmd(4'd3, 8'b0000_0010, 3'd0);
      send_cmd(4'd12, 8'b0000_0010, 3'd0);
      send_cmd(4'd9, 8'b0000_0010, 3'd0);
      check_dest("R6", 1, 4'd9, 3'd0);
      send_ack(8'b0000_0010);
      check_dest("R6", 1, 4'd12, 3'd0);
      send_ack(8'b0000_0010);
      check_dest("R6", 1, 4'd3, 3'd0);
      send_ack(8'b0000_0010);
      check("R6", "drained", 32'(pend_valid_o), 32'h00);
      prio_cfg_i = {16{8'h80}};
   endtask

   task automatic t_requesters;
      send_cmd(4'd7, 8'b0000_1000, 3'd6);
      send_cmd(4'd7, 8'b0000_1000, 3'd2);
      send_cmd(4'd7, 8'b0000_1000, 3'd4);
      check_dest("R7", 3, 4'd7, 3'd2);
      send_ack(8'b0000_1000);
      check_dest("R7", 3, 4'd7, 3'd4);
      send_ack(8'b0000_1000);
      check_dest("R7", 3, 4'd7, 3'd6);
      send_ack(8'b0000_1000);
      check("R7", "drained", 32'(pend_valid_o), 32'h00);
   endtask

   task automatic t_collide;
      send_cmd(4'd1, 8'b0001_0000, 3'd5);
      ack_i = 8'b0001_0000;
      send_cmd(4'd1, 8'b0001_0000, 3'd5);
      ack_i = '0;
      check_dest("R8", 4, 4'd1, 3'd5);
      send_ack(8'b0001_0000);
      check("R8", "cleared after lone ack", 32'(pend_valid_o), 32'h00);
   endtask

   task automatic t_empty_mask;
      send_cmd(4'd6, 8'b0000_0000, 3'd2);
      @(negedge clk_i);
      check("R10", "empty mask sets nothing", 32'(pend_valid_o), 32'h00);
   endtask

   task automatic t_broadcast;
      send_cmd(4'd15, 8'hFF, 3'd7);
      check("R2", "all dests", 32'(pend_valid_o), 32'hFF);
      for (int t = 0; t < 8; t++) check_dest("R5", t, 4'd15, 3'd7);
      send_ack(8'b1010_1010);
      check("R4", "odd dests cleared", 32'(pend_valid_o), 32'h55);
      send_ack(8'hFF);
      check("R4", "all cleared", 32'(pend_valid_o), 32'h00);
   endtask

   initial begin
      repeat (4) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      t_reset();
      t_basic();
      t_repeat();
      t_priority();
      t_requesters();
      t_collide();
      t_empty_mask();
      t_broadcast();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk_i);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule